// File: doc/BRIEF.md
# ATM Header Error Control Generator and Path Integrity Checker

This block sits in the transmit path of an ATM cell stream and deals with the fifth header octet. Cells arrive one byte per clock, qualified by a valid strobe, with a start-of-cell flag on the first byte. A flag sampled with that first byte marks the cell as an idle cell. Every other cell is treated as a user or OAM cell.

For user and OAM cells, the block first compares octet 5 with an expected integrity byte. A mismatch raises a sticky status bit and, when enabled, an interrupt. The block then optionally overwrites octet 5 with a CRC-8 header check sequence computed over octets 1 to 4. An optional coset value can be added to that result. One cell can also be given a deliberately wrong check byte on command. Idle cells carry their own insert enable and are never checked for integrity. Every byte leaves the block one cycle after it enters.

Configuration sits in one 8-bit control register. Bit 0 of that register reads back the integrity status, and a read pulse clears it.

Top module: `hec_unit`

## Requirements
- R1: While rst_ni is low, valid_o, sop_o, data_o, irq_o and ctrl_rdata_o are all zero, and the control register holds 0x00.
- R2: Every accepted byte appears on data_o one cycle after it is accepted. valid_o and sop_o follow valid_i and sop_i with the same one-cycle delay. All octets except octet 5 pass unchanged.
- R3: For a user cell with control bit 5 set, octet 5 is replaced by the CRC-8 of octets 1 to 4. The CRC uses generator 0x07, starts from zero at each start of cell, and takes the most significant bit first.
- R4: With control bit 6 set, the value 0x55 is XORed into the inserted check byte.
- R5: For a user cell with control bit 5 clear, octet 5 is forwarded unchanged.
- R6: An idle cell (idle_i high with the start byte) uses control bit 1 in place of bit 5 to decide on insertion. With bit 1 clear, octet 5 of the idle cell passes unchanged.
- R7: Octet 5 of each user cell is compared with 0x55 when control bit 4 is clear, or with 0xAA when it is set. The comparison is made whether or not insertion is enabled. A mismatch sets status bit 0. Idle cells never set it.
- R8: Status bit 0 stays set until a cycle with ctrl_re_i high. It then clears on the next edge, unless a new mismatch arrives in that same cycle. irq_o equals status bit 0 AND control bit 2.
- R9: A pulse on err_inj_i inverts bit 0 of the next inserted check byte, and only that one. Cells that pass octet 5 unchanged do not use up the request.
- R10: A write stores ctrl_wdata_i[7:1]. Bit 0 cannot be written. ctrl_rdata_o shows the stored bits 7 to 1 with the status in bit 0. Bits 7 and 3 are stored but have no effect on the data stream.
- R11: Bytes are counted only in cycles where valid_i is high, so idle gaps inside a header do not shift octet positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input byte valid |
| sop_i | input | 1 | First byte of a cell |
| idle_i | input | 1 | Cell is an idle cell (sampled with sop_i) |
| data_i | input | 8 | Input byte |
| err_inj_i | input | 1 | Request to corrupt the next inserted check byte |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_re_i | input | 1 | Control register read strobe (clears status) |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read data |
| valid_o | output | 1 | Output byte valid |
| sop_o | output | 1 | Output first byte of a cell |
| data_o | output | 8 | Output byte |
| irq_o | output | 1 | Integrity error interrupt |

## Verification
The bench builds the block with a cell length of 12 and keeps the header length, pattern values and coset at their defaults. Octet 5 and its check byte are therefore tested exactly as in a 53-byte cell, while each cell takes less than a quarter of the cycles. This leaves room for every combination of the two insert enables, coset, pattern select, injection and gapped headers. The short cell also exercises the saturating octet counter and the start-of-cell restart often, in back-to-back cells.

// File: rtl/hec_pkg.sv
package hec_pkg;

  typedef struct packed {
    logic scr_en;       // bit 7, stored only
    logic coset_en;     // bit 6
    logic hec_en;       // bit 5, user/OAM cells
    logic pat_sel;      // bit 4
    logic gfc_en;       // bit 3, stored only
    logic irq_en;       // bit 2
    logic idle_hec_en;  // bit 1
  } cfg_t;

  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc_in ^ data;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/hec_cell_track.sv
module hec_cell_track #(
  parameter int CELL_LEN = 53,
  localparam int IDX_W = $clog2(CELL_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sop_i,
  input  logic             idle_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             idle_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELL_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic             idle_q;

  assign idx_o  = sop_i ? '0 : idx_q;
  assign idle_o = sop_i ? idle_i : idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= IDX_LAST;
      idle_q <= 1'b0;
    end else if (valid_i) begin
      idx_q  <= (idx_o == IDX_LAST) ? IDX_LAST : idx_o + 1'b1;
      idle_q <= idle_o;
    end
  end
endmodule

// File: rtl/hec_crc_acc.sv
module hec_crc_acc #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sop_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  import hec_pkg::*;

  logic [7:0] crc_q;
  logic [7:0] seed;

  assign seed  = sop_i ? 8'h00 : crc_q;
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= 8'h00;
    else if (en_i) crc_q <= crc8_byte(seed, data_i, POLY);
  end
endmodule

// File: rtl/hec_cfg_reg.sv
module hec_cfg_reg (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [7:0]    wdata_i,
  input  logic          err_set_i,
  output hec_pkg::cfg_t cfg_o,
  output logic [7:0]    rdata_o,
  output logic          irq_o
);
  import hec_pkg::*;

  cfg_t cfg_q;
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (we_i) cfg_q <= cfg_t'(wdata_i[7:1]);
      // set beats clear
      if (err_set_i)  err_q <= 1'b1;
      else if (re_i)  err_q <= 1'b0;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q, err_q};
  assign irq_o   = err_q & cfg_q.irq_en;
endmodule

// File: rtl/hec_unit.sv
module hec_unit #(
  parameter int         CELL_LEN = 53,
  parameter int         HDR_LEN  = 4,
  parameter logic [7:0] POLY     = 8'h07,
  parameter logic [7:0] COSET    = 8'h55,
  parameter logic [7:0] PAT_LO   = 8'h55,
  parameter logic [7:0] PAT_HI   = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sop_i,
  input  logic       idle_i,
  input  logic [7:0] data_i,
  input  logic       err_inj_i,
  input  logic       ctrl_we_i,
  input  logic       ctrl_re_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic [7:0] ctrl_rdata_o,
  output logic       valid_o,
  output logic       sop_o,
  output logic [7:0] data_o,
  output logic       irq_o
);
  import hec_pkg::*;

  localparam int IDX_W = $clog2(CELL_LEN);
  localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HDR_LEN);

  cfg_t             cfg;
  logic [IDX_W-1:0] idx;
  logic             cell_idle;
  logic [7:0]       crc;
  logic             in_hdr, at_hec, ins_en, mismatch, consume;
  logic [7:0]       exp_pat, hec_val, out_byte;
  logic             inj_q;

  hec_cell_track #(.CELL_LEN(CELL_LEN)) i_track (
    .clk_i, .rst_ni, .valid_i, .sop_i, .idle_i,
    .idx_o (idx),
    .idle_o(cell_idle)
  );

  assign in_hdr = valid_i && (idx < HEC_IDX);

  hec_crc_acc #(.POLY(POLY)) i_crc (
    .clk_i, .rst_ni,
    .en_i  (in_hdr),
    .sop_i,
    .data_i,
    .crc_o (crc)
  );

  assign at_hec   = valid_i && (idx == HEC_IDX);
  assign ins_en   = cell_idle ? cfg.idle_hec_en : cfg.hec_en;
  assign exp_pat  = cfg.pat_sel ? PAT_HI : PAT_LO;
  assign mismatch = at_hec && !cell_idle && (data_i != exp_pat);
  assign consume  = at_hec && ins_en;
  assign hec_val  = crc ^ (cfg.coset_en ? COSET : 8'h00) ^ {7'b0, inj_q};
  assign out_byte = consume ? hec_val : data_i;

  hec_cfg_reg i_cfg (
    .clk_i, .rst_ni,
    .we_i     (ctrl_we_i),
    .re_i     (ctrl_re_i),
    .wdata_i  (ctrl_wdata_i),
    .err_set_i(mismatch),
    .cfg_o    (cfg),
    .rdata_o  (ctrl_rdata_o),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inj_q   <= 1'b0;
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      data_o  <= 8'h00;
    end else begin
      inj_q   <= (inj_q & ~consume) | err_inj_i;
      valid_o <= valid_i;
      sop_o   <= valid_i & sop_i;
      if (valid_i) data_o <= out_byte;
    end
  end
endmodule

// File: rtl/hec_unit_chk.sv
module hec_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       sop_i,
  input logic [7:0] data_i,
  input logic       ctrl_re_i,
  input logic [7:0] ctrl_rdata_o,
  input logic       valid_o,
  input logic       sop_o,
  input logic [7:0] data_o,
  input logic       irq_o
);
  a_r2_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_first_octet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i) |=> (sop_o && data_o == $past(data_i)));
  a_r2_sop_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> valid_o);
  a_r8_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_rdata_o[0] && ctrl_rdata_o[2]));
  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_re_i && !valid_i) |=> !ctrl_rdata_o[0]);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[0] && !ctrl_re_i) |=> ctrl_rdata_o[0]);
  a_r10_status_not_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !ctrl_rdata_o[0]) |=> !ctrl_rdata_o[0]);
endmodule

bind hec_unit hec_unit_chk i_hec_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .sop_i       (sop_i),
  .data_i      (data_i),
  .ctrl_re_i   (ctrl_re_i),
  .ctrl_rdata_o(ctrl_rdata_o),
  .valid_o     (valid_o),
  .sop_o       (sop_o),
  .data_o      (data_o),
  .irq_o       (irq_o)
);

// File: tb/test_hec_unit.sv
module test_hec_unit;
  localparam int CLEN = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0, sop_i = 1'b0, idle_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       err_inj_i = 1'b0;
  logic       ctrl_we_i = 1'b0, ctrl_re_i = 1'b0;
  logic [7:0] ctrl_wdata_i = 8'h00;
  logic [7:0] ctrl_rdata_o;
  logic       valid_o, sop_o, irq_o;
  logic [7:0] data_o;

  int n_chk = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  // bench model of configuration
  logic m_coset = 0, m_hec = 0, m_idle = 0, m_inj = 0;

  always #4 clk_i = ~clk_i;

  hec_unit #(.CELL_LEN(CLEN)) i_hec_unit (
    .clk_i, .rst_ni, .valid_i, .sop_i, .idle_i, .data_i, .err_inj_i,
    .ctrl_we_i, .ctrl_re_i, .ctrl_wdata_i, .ctrl_rdata_o,
    .valid_o, .sop_o, .data_o, .irq_o
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: actual unexpected byte %h expected none", data_o);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({23'b0, sop_o, data_o}, {23'b0, e}, t);
      end
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(posedge clk_i); #1;
    ctrl_we_i = 1'b0;
    m_coset = v[6]; m_hec = v[5]; m_idle = v[1];
  endtask

  task automatic read_cfg(input logic [7:0] exp, input string tag);
    ctrl_re_i = 1'b1;
    #2 check({24'b0, ctrl_rdata_o}, {24'b0, exp}, tag);
    @(posedge clk_i); #1;
    ctrl_re_i = 1'b0;
  endtask

  task automatic inject;
    err_inj_i = 1'b1;
    @(posedge clk_i); #1;
    err_inj_i = 1'b0;
    m_inj = 1'b1;
  endtask

  task automatic send_cell(input logic [31:0] hdr, input logic [7:0] o5,
                           input logic idle, input logic gaps, input string tag);
    logic [7:0] e5, b;
    logic ins;
    ins = idle ? m_idle : m_hec;
    if (ins) begin
      e5 = ref_crc(hdr) ^ (m_coset ? 8'h55 : 8'h00) ^ {7'b0, m_inj};
      m_inj = 1'b0;
    end else e5 = o5;
    for (int k = 0; k < CLEN; k++) begin
      if (k < 4)       b = hdr[31 - 8*k -: 8];
      else if (k == 4) b = o5;
      else             b = 8'(k * 7) ^ hdr[7:0];
      exp_q.push_back({k == 0, (k == 4) ? e5 : b});
      tag_q.push_back(tag);
      valid_i = 1'b1; sop_i = (k == 0); idle_i = idle; data_i = b;
      @(posedge clk_i); #1;
      if (gaps && k < 5) begin
        valid_i = 1'b0; sop_i = 1'b0; data_i = 8'hEE;
        @(posedge clk_i); #1;
      end
    end
    valid_i = 1'b0; sop_i = 1'b0; idle_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    check({valid_o, sop_o, irq_o}, 0, "R1 flags");
    check({24'b0, data_o}, 0, "R1 data");
    check({24'b0, ctrl_rdata_o}, 0, "R1 ctrl");
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R3 R4: coset on, inserts on, irq on, pattern 0x55
    write_cfg(8'h66);
    read_cfg(8'h66, "R10 readback");
    send_cell(32'h0000_0001, 8'h55, 1'b0, 1'b0, "R3 R4 user coset");
    check({24'b0, ctrl_rdata_o}, 32'h66, "R7 match no status");
    send_cell(32'h0000_0001, 8'h00, 1'b1, 1'b0, "R6 idle insert");
    check({31'b0, ctrl_rdata_o[0]}, 0, "R7 idle not checked");

    // R3 without coset, R11 gapped header
    write_cfg(8'h26);
    send_cell(32'h1234_5678, 8'h55, 1'b0, 1'b0, "R3 plain crc");
    send_cell(32'hA5C3_0F99, 8'h55, 1'b0, 1'b1, "R11 gapped");
    send_cell(32'hFFFF_FFFF, 8'h55, 1'b0, 1'b0, "R3 ones");

    // R7 R8: mismatch sets status and irq
    send_cell(32'h0102_0304, 8'h00, 1'b0, 1'b0, "R3 mismatch cell");
    check({31'b0, irq_o}, 1, "R8 irq on error");
    read_cfg(8'h27, "R7 status set");
    check({31'b0, ctrl_rdata_o[0]}, 0, "R8 status cleared");
    check({31'b0, irq_o}, 0, "R8 irq cleared");

    // R8 irq masked
    write_cfg(8'h22);
    send_cell(32'h0102_0304, 8'h11, 1'b0, 1'b0, "R3 masked cell");
    check({31'b0, irq_o}, 0, "R8 irq masked");
    check({31'b0, ctrl_rdata_o[0]}, 1, "R7 status masked irq");
    read_cfg(8'h23, "R8 read masked");

    // R7 pattern select 0xAA
    write_cfg(8'h36);
    send_cell(32'h0BAD_F00D, 8'hAA, 1'b0, 1'b0, "R7 AA cell");
    check({31'b0, ctrl_rdata_o[0]}, 0, "R7 AA match");
    send_cell(32'h0BAD_F00D, 8'h55, 1'b0, 1'b0, "R7 AA mismatch cell");
    check({31'b0, ctrl_rdata_o[0]}, 1, "R7 AA mismatch");
    read_cfg(8'h37, "R8 clear AA");

    // R5: user insert off, idle insert on; R7 checked without insertion
    write_cfg(8'h12);
    send_cell(32'h0000_0000, 8'h3C, 1'b0, 1'b0, "R5 passthrough");
    check({31'b0, ctrl_rdata_o[0]}, 1, "R7 check w/o insert");
    read_cfg(8'h13, "R8 clear");
    send_cell(32'hDEAD_BEEF, 8'h77, 1'b1, 1'b0, "R6 idle uses bit1");

    // R6: idle insert off, user on
    write_cfg(8'h20);
    send_cell(32'h0000_0001, 8'h52, 1'b1, 1'b0, "R6 idle passthrough");
    send_cell(32'h0000_0001, 8'h55, 1'b0, 1'b0, "R6 user still inserts");

    // R9: injection consumed only by an inserted cell
    inject();
    send_cell(32'h0000_0001, 8'h6A, 1'b1, 1'b0, "R9 idle no consume");
    send_cell(32'h4455_6677, 8'h55, 1'b0, 1'b0, "R9 flipped");
    send_cell(32'h4455_6677, 8'h55, 1'b0, 1'b0, "R9 once only");
    write_cfg(8'h62);
    inject();
    send_cell(32'h0000_0001, 8'h00, 1'b1, 1'b0, "R9 idle flipped coset");

    // R10: bits 7 and 3 no effect, bit 0 not writable
    write_cfg(8'hFF);
    read_cfg(8'hFE, "R10 bit0 not writable");
    send_cell(32'hCAFE_0001, 8'hAA, 1'b0, 1'b0, "R10 scr gfc no effect");
    write_cfg(8'h88);
    send_cell(32'hCAFE_0002, 8'h55, 1'b0, 1'b0, "R10 stored only");
    read_cfg(8'h88, "R10 readback 88");

    repeat (4) @(posedge clk_i);
    #1 check(exp_q.size(), 0, "R2 all bytes emitted");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule